// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block is a 16-bit up/down counter whose stepping source is chosen by a 3-bit mode field. The same counter can run from the internal tick, follow a two-channel quadrature encoder in one of three ways, or take orders from a trigger line. A trigger can restart it, gate it, start it once, or clock it directly. The counter wraps between zero and a reload bound. Each wrap, and each restart from the trigger, raises a one-cycle update pulse.

The two encoder channels and the trigger arrive asynchronously. Each passes through a two-stage synchroniser, and edges are detected on the synchronised copies. The mode field, the enables, the direction setting and the reload bound are treated as already synchronous to the clock. In the gated mode the trigger level is sampled. That mode is therefore meant for a level-type trigger source, not for one that emits a single pulse per transition.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `cnt_val`, `dir_down`, `upd_pulse` and `trig_flag` to 0, and it clears the latched start of mode 6.
- R2: With `mode_sel` = 0, the counter steps once on each clock edge where `tick_en` is 1 and the run condition (`cnt_en` or the latched start) holds. Otherwise it keeps its value.
- R3: Counting up from a value at or above `reload_val` gives 0. Counting down from 0 gives `reload_val`. Either wrap sets `upd_pulse` high for exactly one cycle; ordinary steps leave it low.
- R4: With `mode_sel` = 1, each edge of channel 2 gives one step. The step is up when the two channels are equal after the edge and down when they differ.
- R5: With `mode_sel` = 2, each edge of channel 1 gives one step. The step is up when the two channels differ after the edge and down when they are equal.
- R6: With `mode_sel` = 3, an edge on either channel gives one step, using the rule of R4 or R5 for that channel. A full quadrature cycle therefore gives four steps. An edge on both channels in the same cycle gives no step. In modes 1 to 3, `dir_down` shows the direction of the last step.
- R7: With `mode_sel` = 4, the counter steps as in R2. A rising trigger edge loads 0 if `dir_cfg` is 0, or loads `reload_val` if `dir_cfg` is 1, and raises `upd_pulse`. The restart takes priority over a step in the same cycle.
- R8: With `mode_sel` = 5, the counter steps as in R2 only while the synchronised trigger is high. When the trigger is low it holds its value and is not cleared. `trig_flag` pulses on both trigger edges.
- R9: With `mode_sel` = 6, a rising trigger edge latches a start that acts like `cnt_en` until reset. The count is not cleared, and counting begins on the following cycle.
- R10: With `mode_sel` = 7, the counter steps once per rising trigger edge while `cnt_en` is 1, and `tick_en` has no effect.
- R11: A change on `ch1_in`, `ch2_in` or `trig_in` set up before clock edge k changes the outputs at edge k+2, the third edge that samples the new level.
- R12: In modes 0 and 4 to 7, the count direction follows `dir_cfg`, and `dir_down` equals the `dir_cfg` value from the previous edge. `trig_flag` pulses for one cycle on the trigger events named in R7 to R10 and stays 0 in modes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Slave behaviour select (0 to 7) |
| cnt_en | input | 1 | Counter run enable |
| tick_en | input | 1 | Internal clock enable for tick-driven modes |
| dir_cfg | input | 1 | Count direction in non-encoder modes, 1 = down |
| ch1_in | input | 1 | Encoder channel 1, asynchronous |
| ch2_in | input | 1 | Encoder channel 2, asynchronous |
| trig_in | input | 1 | Trigger input, asynchronous |
| reload_val | input | 16 | Upper wrap bound |
| cnt_val | output | 16 | Counter value |
| dir_down | output | 1 | Direction of counting, 1 = down |
| upd_pulse | output | 1 | One-cycle update event on a wrap or a trigger restart |
| trig_flag | output | 1 | One-cycle trigger event |

## Verification
Results caused by `ch1_in`, `ch2_in` or `trig_in` appear on the third rising edge after the input changes: two synchroniser stages, then the counter register. Results caused by `mode_sel`, the enables, `dir_cfg` and `reload_val` appear on the next edge. The bench reference model delays the asynchronous inputs through its own sample history and applies the direct inputs at once. It then compares every output at each falling edge, halfway between the edges that update them. A directed check raises the trigger in mode 7 and confirms that the count is still unchanged after two edges and has stepped after the third.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [2:0] {
        MODE_FREE   = 3'd0,
        MODE_ENC_B  = 3'd1,
        MODE_ENC_A  = 3'd2,
        MODE_ENC_AB = 3'd3,
        MODE_RESET  = 3'd4,
        MODE_GATED  = 3'd5,
        MODE_START  = 3'd6,
        MODE_EXTCLK = 3'd7
    } slave_mode_e;

    // Synchronised view of one asynchronous line
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    // One cycle's request to the counter
    typedef struct packed {
        logic step;
        logic down;
        logic dir_upd;
        logic reinit;
        logic trig_evt;
    } step_req_t;

    // Direction for a channel 1 edge: up when the channels differ afterwards
    function automatic logic down_on_ch1(logic a, logic b);
        return ~(a ^ b);
    endfunction

    // Direction for a channel 2 edge: up when the channels match afterwards
    function automatic logic down_on_ch2(logic a, logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [CHAIN-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[CHAIN-2:0], d_i[g]};
        end

        assign lvl_o[g]  = sh[STAGES-1];
        assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
        assign fall_o[g] = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/tsc_step_decode.sv
module tsc_step_decode
    import tsc_pkg::*;
(
    input  slave_mode_e mode_i,
    input  logic        run_i,
    input  logic        tick_i,
    input  logic        dir_cfg_i,
    input  edge_t       a_i,
    input  edge_t       b_i,
    input  edge_t       t_i,
    output step_req_t   req_o
);
    logic a_edge, b_edge;

    assign a_edge = a_i.rise | a_i.fall;
    assign b_edge = b_i.rise | b_i.fall;

    always_comb begin
        req_o         = '0;
        req_o.down    = dir_cfg_i;
        req_o.dir_upd = 1'b1;
        unique case (mode_i)
            MODE_FREE: req_o.step = run_i & tick_i;
            MODE_ENC_B: begin
                req_o.step    = run_i & b_edge;
                req_o.down    = down_on_ch2(a_i.lvl, b_i.lvl);
                req_o.dir_upd = run_i & b_edge;
            end
            MODE_ENC_A: begin
                req_o.step    = run_i & a_edge;
                req_o.down    = down_on_ch1(a_i.lvl, b_i.lvl);
                req_o.dir_upd = run_i & a_edge;
            end
            MODE_ENC_AB: begin
                req_o.step    = run_i & (a_edge ^ b_edge);
                req_o.down    = a_edge ? down_on_ch1(a_i.lvl, b_i.lvl)
                                       : down_on_ch2(a_i.lvl, b_i.lvl);
                req_o.dir_upd = run_i & (a_edge ^ b_edge);
            end
            MODE_RESET: begin
                req_o.step     = run_i & tick_i;
                req_o.reinit   = t_i.rise;
                req_o.trig_evt = t_i.rise;
            end
            MODE_GATED: begin
                req_o.step     = run_i & tick_i & t_i.lvl;
                req_o.trig_evt = t_i.rise | t_i.fall;
            end
            MODE_START: begin
                req_o.step     = run_i & tick_i;
                req_o.trig_evt = t_i.rise;
            end
            MODE_EXTCLK: begin
                req_o.step     = run_i & t_i.rise;
                req_o.trig_evt = t_i.rise;
            end
            default: req_o = '0;
        endcase
    end
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_req_t        req_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o,
    output logic             tflag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q, upd_q, tflag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            upd_q   <= 1'b0;
            tflag_q <= 1'b0;
        end else begin
            upd_q   <= 1'b0;
            tflag_q <= req_i.trig_evt;
            if (req_i.dir_upd) dir_q <= req_i.down;
            if (req_i.reinit) begin
                cnt_q <= req_i.down ? reload_i : '0;
                upd_q <= 1'b1;
            end else if (req_i.step) begin
                if (!req_i.down) begin
                    if (cnt_q >= reload_i) begin
                        cnt_q <= '0;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_q <= reload_i;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign dir_o   = dir_q;
    assign upd_o   = upd_q;
    assign tflag_o = tflag_q;

    // R3: upward wrap to zero with an update event
    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i.step && !req_i.reinit && !req_i.down && cnt_q >= reload_i)
        |=> (cnt_q == '0 && upd_q));

    // R3: downward wrap to the reload bound with an update event
    assert_down_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i.step && !req_i.reinit && req_i.down && cnt_q == '0)
        |=> (cnt_q == $past(reload_i) && upd_q));

    // R7: a trigger restart while counting up clears the count
    assert_reinit_up_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i.reinit && !req_i.down) |=> (cnt_q == '0 && upd_q));

    // R2: without a step or a restart the count holds and no update fires
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_i.step && !req_i.reinit) |=> ($stable(cnt_q) && !upd_q));
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tsc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic             cnt_en,
    input  logic             tick_en,
    input  logic             dir_cfg,
    input  logic             ch1_in,
    input  logic             ch2_in,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             dir_down,
    output logic             upd_pulse,
    output logic             trig_flag
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] s_lvl, s_rise, s_fall;
    edge_t             a_e, b_e, t_e;
    slave_mode_e       mode;
    logic              started_q, run;
    step_req_t         req;

    tsc_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({trig_in, ch2_in, ch1_in}),
        .lvl_o  (s_lvl),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    assign a_e  = '{lvl: s_lvl[0], rise: s_rise[0], fall: s_fall[0]};
    assign b_e  = '{lvl: s_lvl[1], rise: s_rise[1], fall: s_fall[1]};
    assign t_e  = '{lvl: s_lvl[2], rise: s_rise[2], fall: s_fall[2]};
    assign mode = slave_mode_e'(mode_sel);

    // Start latched by the trigger in mode 6; only reset clears it
    always_ff @(posedge clk) begin
        if (rst)                                started_q <= 1'b0;
        else if (mode == MODE_START && t_e.rise) started_q <= 1'b1;
    end

    assign run = cnt_en | started_q;

    tsc_step_decode u_dec (
        .mode_i    (mode),
        .run_i     (run),
        .tick_i    (tick_en),
        .dir_cfg_i (dir_cfg),
        .a_i       (a_e),
        .b_i       (b_e),
        .t_i       (t_e),
        .req_o     (req)
    );

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .reload_i (reload_val),
        .cnt_o    (cnt_val),
        .dir_o    (dir_down),
        .upd_o    (upd_pulse),
        .tflag_o  (trig_flag)
    );

    // R8: a low synchronised trigger freezes the count in gated mode
    assert_gated_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_GATED && !t_e.lvl) |=> $stable(cnt_val));

    // R9: once latched, the start stays set until reset
    assert_start_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        started_q |=> started_q);
endmodule

// File: tb/tmr_slave_ctrl_test.sv
module tmr_slave_ctrl_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   mode_sel = 3'd0;
    logic         cnt_en = 1'b0, tick_en = 1'b0, dir_cfg = 1'b0;
    logic         ch1_in = 1'b0, ch2_in = 1'b0, trig_in = 1'b0;
    logic [W-1:0] reload_val = 16'd10;
    logic [W-1:0] cnt_val;
    logic         dir_down, upd_pulse, trig_flag;

    int tests = 0, fails = 0, wd = 0, qi = 0;

    // reference model state
    int m_cnt;
    bit m_dir, m_upd, m_tf, m_started;
    bit h1[$], h2[$], ht[$];
    bit s1, p1, s2, p2, st, pt, tr, tf, run, step, down, reinit, tev, dupd, moved;
    int d;

    tmr_slave_ctrl uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cnt_en(cnt_en),
        .tick_en(tick_en), .dir_cfg(dir_cfg), .ch1_in(ch1_in), .ch2_in(ch2_in),
        .trig_in(trig_in), .reload_val(reload_val), .cnt_val(cnt_val),
        .dir_down(dir_down), .upd_pulse(upd_pulse), .trig_flag(trig_flag)
    );

    always #5 clk = ~clk;

    function automatic int gidx(bit a, bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_dir = 0; m_upd = 0; m_tf = 0; m_started = 0;
            h1 = '{0, 0, 0}; h2 = '{0, 0, 0}; ht = '{0, 0, 0};
        end else begin
            s1 = h1[1]; p1 = h1[0]; s2 = h2[1]; p2 = h2[0]; st = ht[1]; pt = ht[0];
            tr = st && !pt; tf = !st && pt;
            run = cnt_en || m_started;
            step = 0; down = dir_cfg; reinit = 0; tev = 0; dupd = 1;
            case (mode_sel)
                3'd0: step = run && tick_en;
                3'd1, 3'd2, 3'd3: begin
                    dupd = 0;
                    d = (gidx(s1, s2) - gidx(p1, p2) + 4) % 4;
                    moved = (mode_sel == 3'd1) ? (s2 != p2) :
                            (mode_sel == 3'd2) ? (s1 != p1) : 1'b1;
                    if (run && moved && (d == 1 || d == 3)) begin
                        step = 1; down = (d == 3); dupd = 1;
                    end
                end
                3'd4: begin step = run && tick_en; reinit = tr; tev = tr; end
                3'd5: begin step = run && tick_en && st; tev = tr || tf; end
                3'd6: begin step = run && tick_en; tev = tr; if (tr) m_started = 1; end
                default: begin step = run && tr; tev = tr; end
            endcase
            m_upd = 0; m_tf = tev;
            if (dupd) m_dir = down;
            if (reinit) begin
                m_cnt = down ? int'(reload_val) : 0; m_upd = 1;
            end else if (step) begin
                if (!down) begin
                    if (m_cnt >= int'(reload_val)) begin m_cnt = 0; m_upd = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = int'(reload_val); m_upd = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            h1.push_back(ch1_in); void'(h1.pop_front());
            h2.push_back(ch2_in); void'(h2.pop_front());
            ht.push_back(trig_in); void'(ht.pop_front());
        end
    end

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (int'(cnt_val) != m_cnt || dir_down != m_dir ||
                upd_pulse != m_upd || trig_flag != m_tf) begin
                fails++;
                $display("FAIL %s%s%s: cnt=%0d dir=%0b upd=%0b tf=%0b expected cnt=%0d dir=%0b upd=%0b tf=%0b",
                         mode_tag(mode_sel), (upd_pulse != m_upd) ? "/R3" : "",
                         (dir_down != m_dir) ? "/R12" : "",
                         cnt_val, dir_down, upd_pulse, trig_flag, m_cnt, m_dir, m_upd, m_tf);
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quad(bit fwd, int n, int hold);
        for (int i = 0; i < n; i++) begin
            qi = fwd ? (qi + 1) % 4 : (qi + 3) % 4;
            ch1_in = (qi == 1 || qi == 2);
            ch2_in = (qi == 2 || qi == 3);
            cyc(hold);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", wd, 0);
            finish_run();
        end
    end

    int c0;
    initial begin
        cyc(3);
        // R1: reset state
        chk(cnt_val == 0 && !dir_down && !upd_pulse && !trig_flag, "R1",
            int'(cnt_val), 0);
        rst = 0;
        // R2/R3: free counting with wraps both ways
        mode_sel = 3'd0; cnt_en = 1; tick_en = 1;
        cyc(25);
        tick_en = 0; cyc(3); tick_en = 1; cyc(2);
        cnt_en = 0; cyc(5);
        cnt_en = 1; dir_cfg = 1; cyc(15);
        cyc(1);
        // R12: direction follows dir_cfg
        chk(dir_down == 1'b1, "R12", int'(dir_down), 1);
        dir_cfg = 0;
        // R6, R4, R5: encoder variants
        reload_val = 16'd100;
        mode_sel = 3'd3; quad(1, 8, 4); quad(0, 6, 4);
        c0 = int'(cnt_val);
        quad(1, 4, 4);
        chk(int'(cnt_val) == (c0 + 4) % 101, "R6", int'(cnt_val), (c0 + 4) % 101);
        mode_sel = 3'd1; quad(1, 8, 4); quad(0, 4, 4);
        mode_sel = 3'd2; quad(1, 8, 4); quad(0, 6, 4);
        // R7: trigger restart
        reload_val = 16'd20; mode_sel = 3'd4;
        cyc(10); trig_in = 1; cyc(5); trig_in = 0; cyc(8);
        dir_cfg = 1; trig_in = 1; cyc(5); trig_in = 0; cyc(6);
        chk(dir_down == 1'b1, "R12", int'(dir_down), 1);
        dir_cfg = 0;
        // R8: gated counting
        mode_sel = 3'd5;
        for (int k = 0; k < 4; k++) begin
            trig_in = 1; cyc(6 + k); trig_in = 0; cyc(5);
        end
        // R10 and R11: external clock and input latency
        mode_sel = 3'd7; tick_en = 0; reload_val = 16'd200; cyc(4);
        c0 = int'(cnt_val);
        trig_in = 1; cyc(2);
        chk(int'(cnt_val) == c0, "R11", int'(cnt_val), c0);
        cyc(1);
        chk(int'(cnt_val) == c0 + 1, "R11", int'(cnt_val), c0 + 1);
        trig_in = 0; cyc(4);
        for (int k = 0; k < 5; k++) begin
            trig_in = 1; cyc(3); trig_in = 0; cyc(3);
        end
        chk(int'(cnt_val) == c0 + 6, "R10", int'(cnt_val), c0 + 6);
        // R9: start on trigger, no clear
        mode_sel = 3'd6; cnt_en = 0; tick_en = 1; cyc(6);
        c0 = int'(cnt_val);
        chk(int'(cnt_val) == c0, "R9", int'(cnt_val), c0);
        trig_in = 1; cyc(3); trig_in = 0; cyc(10);
        chk(int'(cnt_val) != c0, "R9", int'(cnt_val), c0 + 10);
        cyc(3);
        finish_run();
    end
endmodule